// File: doc/BRIEF.md
# SPI Transfer Request Parameter Checker

This block decides whether one SPI transfer request can be carried out by a host controller with a given set of capabilities. A request names a chip select, a word size, a chip-select toggle flag, transmit and receive lane widths, a 32-bit mode word, a clock frequency and four timing delays. The block compares each of these against a fixed capability set and returns a two-bit result code.

The capability inputs are static for the duration of a request and are read-only from the block's point of view. The checker has no state beyond its output register. One clock after `req_valid` is high, `res_valid` pulses and `res_code` carries the verdict. Several different encodings meet in one place. The chip-select toggle capability is inverted, so a set bit means unsupported. Clock phase and clock polarity support each use a two-bit "both / only 0 / only 1 / invalid" field. A zero maximum frequency means no limit. A zero maximum delay means the delay cannot be used at all.

Top module: `spi_req_checker`

## Requirements
- R1: `res_valid` is high in exactly those cycles whose previous clock edge saw `req_valid` high with `rst` low. The verdict for the request in that previous cycle is on `res_code` in the same cycle.
- R2: `res_code` is 0 for acceptance and 1 for a parameter error. The checker never outputs 2 (transfer error, reserved for the serial engine) or 3. While `res_valid` is low, `res_code` is 0.
- R3: A request is rejected when `req_cs` is greater than or equal to `cap_cs_count`.
- R4: When `cap_word_mask` is zero, every word size is accepted. When it is nonzero, word size w is accepted only if 1 ≤ w ≤ 32 and bit w−1 of the mask is set.
- R5: When `cap_cs_toggle_unsup` is 1, a request with `req_cs_toggle` = 1 is rejected. When `cap_cs_toggle_unsup` is 0, the flag is always accepted.
- R6: For each direction, a lane-width value other than 0, 1, 2, 4 or 8 is rejected.
- R7: In each lane-support mask, bit 0 enables width 2, bit 1 enables width 4 and bit 2 enables width 8. A width of 2, 4 or 8 whose bit is clear is rejected. Widths 0 and 1 are always accepted.
- R8: Clock phase is `req_mode` bit 0 and clock polarity is bit 1. They are checked against `cap_mode[1:0]` and `cap_mode[3:2]` respectively. In each field, 00 allows both values, 01 allows only 0 and 10 allows only 1. The value 11 rejects every request.
- R9: `req_mode` bit 2 (active-high select), bit 3 (LSB first) and bit 4 (loopback) are rejected when set unless `cap_mode` bit 4, bit 5 or bit 6 respectively is set.
- R10: A request with any of `req_mode[31:5]` nonzero is rejected.
- R11: A request is rejected when `cap_max_freq` is nonzero and `req_freq` exceeds it. When `cap_max_freq` is zero, any frequency is accepted.
- R12: The delay vectors hold four 32-bit slots at `[32*i +: 32]`: i=0 inter-word gap, 1 select setup, 2 select hold, 3 select inactive. For each slot, a nonzero request is rejected when the maximum is zero, or when the request exceeds a nonzero maximum. A zero request is always accepted.
- R13: While `rst` is high, and in the first cycle after it, `res_valid` and `res_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request fields are valid this cycle |
| cap_cs_count | input | 8 | Number of chip selects available |
| cap_cs_toggle_unsup | input | 1 | 1 = toggling select between transfers is unsupported |
| cap_tx_lanes | input | 3 | Transmit multi-lane support mask |
| cap_rx_lanes | input | 3 | Receive multi-lane support mask |
| cap_word_mask | input | 32 | Supported word sizes, zero = any |
| cap_mode | input | 7 | Phase/polarity support fields and optional mode gates |
| cap_max_freq | input | 32 | Maximum frequency, zero = unlimited |
| cap_max_dly | input | 128 | Four maximum delays, zero = unsupported |
| req_cs | input | 8 | Requested chip select index |
| req_word_bits | input | 8 | Requested bits per word |
| req_cs_toggle | input | 1 | Deassert select before next transfer |
| req_tx_lanes | input | 8 | Requested transmit lane width |
| req_rx_lanes | input | 8 | Requested receive lane width |
| req_mode | input | 32 | Requested mode word |
| req_freq | input | 32 | Requested frequency |
| req_dly | input | 128 | Four requested delays |
| res_valid | output | 1 | Verdict strobe |
| res_code | output | 2 | Verdict code |

## Verification
The hardest case is a request that fails exactly one check while every other field is legal. Such a request shows whether each rule is wired to the verdict on its own. Uniform random fields nearly always trip several rules at once, which hides a missing or inverted check. The stimulus therefore starts from a fully permissive capability set and a benign request, and changes one field per directed vector, on both sides of each boundary: equal to the maximum and one above it, count minus one and count, zero maximum with a zero and a nonzero request. Random vectors are then drawn from small, boundary-heavy value sets, so that both verdicts appear often.

// File: rtl/spi_req_chk_pkg.sv
package spi_req_chk_pkg;

  typedef enum logic [1:0] {
    RES_OK        = 2'd0,
    RES_PARAM_ERR = 2'd1,
    RES_XFER_ERR  = 2'd2
  } res_code_e;

  // Two-bit support field: both / only 0 / only 1 / invalid
  function automatic logic pick_ok(input logic [1:0] field, input logic want);
    case (field)
      2'b00:   pick_ok = 1'b1;
      2'b01:   pick_ok = ~want;
      2'b10:   pick_ok = want;
      default: pick_ok = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/spi_lane_check.sv
module spi_lane_check #(
  parameter int LANE_W = 8,
  parameter int SUP_W  = 3
) (
  input  logic [LANE_W-1:0] lanes,
  input  logic [SUP_W-1:0]  sup_mask,
  output logic              ok
);
  always_comb begin
    case (lanes)
      LANE_W'(0), LANE_W'(1): ok = 1'b1;
      LANE_W'(2):             ok = sup_mask[0];
      LANE_W'(4):             ok = sup_mask[1];
      LANE_W'(8):             ok = sup_mask[2];
      default:                ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/spi_mode_check.sv
module spi_mode_check
  import spi_req_chk_pkg::*;
#(
  parameter int MODE_W     = 32,
  parameter int CAP_MODE_W = 7
) (
  input  logic [CAP_MODE_W-1:0] cap_mode,
  input  logic [MODE_W-1:0]     req_mode,
  output logic                  ok
);
  localparam int NUM_OPT = 3;  // select-high, lsb-first, loopback
  localparam int OPT_REQ = 2;  // first optional bit in request
  localparam int OPT_CAP = 4;  // first optional bit in capability
  localparam int USED_W  = OPT_REQ + NUM_OPT;

  logic [NUM_OPT-1:0] opt_ok;
  logic               phase_ok, pol_ok, rsvd_ok;

  assign phase_ok = pick_ok(cap_mode[1:0], req_mode[0]);
  assign pol_ok   = pick_ok(cap_mode[3:2], req_mode[1]);
  assign rsvd_ok  = (req_mode[MODE_W-1:USED_W] == '0);

  for (genvar g = 0; g < NUM_OPT; g++) begin : g_opt
    assign opt_ok[g] = ~req_mode[OPT_REQ+g] | cap_mode[OPT_CAP+g];
  end

  assign ok = phase_ok & pol_ok & rsvd_ok & (&opt_ok);
endmodule

// File: rtl/spi_limit_check.sv
module spi_limit_check #(
  parameter int   VAL_W          = 32,
  parameter logic ZERO_UNLIMITED = 1'b0
) (
  input  logic [VAL_W-1:0] limit,
  input  logic [VAL_W-1:0] req,
  output logic             ok
);
  always_comb begin
    if (req == '0)        ok = 1'b1;
    else if (limit == '0) ok = ZERO_UNLIMITED;
    else                  ok = (req <= limit);
  end
endmodule

// File: rtl/spi_req_checker.sv
module spi_req_checker
  import spi_req_chk_pkg::*;
#(
  parameter int ID_W       = 8,
  parameter int WB_W       = 8,
  parameter int MASK_W     = 32,
  parameter int LANE_W     = 8,
  parameter int SUP_W      = 3,
  parameter int MODE_W     = 32,
  parameter int CAP_MODE_W = 7,
  parameter int FREQ_W     = 32,
  parameter int DLY_W      = 32,
  parameter int NUM_DLY    = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [ID_W-1:0]          cap_cs_count,
  input  logic                     cap_cs_toggle_unsup,
  input  logic [SUP_W-1:0]         cap_tx_lanes,
  input  logic [SUP_W-1:0]         cap_rx_lanes,
  input  logic [MASK_W-1:0]        cap_word_mask,
  input  logic [CAP_MODE_W-1:0]    cap_mode,
  input  logic [FREQ_W-1:0]        cap_max_freq,
  input  logic [NUM_DLY*DLY_W-1:0] cap_max_dly,
  input  logic [ID_W-1:0]          req_cs,
  input  logic [WB_W-1:0]          req_word_bits,
  input  logic                     req_cs_toggle,
  input  logic [LANE_W-1:0]        req_tx_lanes,
  input  logic [LANE_W-1:0]        req_rx_lanes,
  input  logic [MODE_W-1:0]        req_mode,
  input  logic [FREQ_W-1:0]        req_freq,
  input  logic [NUM_DLY*DLY_W-1:0] req_dly,
  output logic                     res_valid,
  output logic [1:0]               res_code
);
  logic               cs_ok, word_ok, toggle_ok, tx_ok, rx_ok, mode_ok, freq_ok;
  logic [NUM_DLY-1:0] dly_ok;
  logic               all_ok;
  logic               word_hit;
  res_code_e          code_q;

  assign cs_ok     = (req_cs < cap_cs_count);
  assign toggle_ok = ~(cap_cs_toggle_unsup & req_cs_toggle);

  always_comb begin
    word_hit = 1'b0;
    for (int i = 0; i < MASK_W; i++)
      if (req_word_bits == WB_W'(i + 1)) word_hit = cap_word_mask[i];
  end
  assign word_ok = (cap_word_mask == '0) | word_hit;

  spi_lane_check #(.LANE_W(LANE_W), .SUP_W(SUP_W)) tx_lane_i (
    .lanes(req_tx_lanes), .sup_mask(cap_tx_lanes), .ok(tx_ok));
  spi_lane_check #(.LANE_W(LANE_W), .SUP_W(SUP_W)) rx_lane_i (
    .lanes(req_rx_lanes), .sup_mask(cap_rx_lanes), .ok(rx_ok));

  spi_mode_check #(.MODE_W(MODE_W), .CAP_MODE_W(CAP_MODE_W)) mode_i (
    .cap_mode(cap_mode), .req_mode(req_mode), .ok(mode_ok));

  spi_limit_check #(.VAL_W(FREQ_W), .ZERO_UNLIMITED(1'b1)) freq_i (
    .limit(cap_max_freq), .req(req_freq), .ok(freq_ok));

  for (genvar d = 0; d < NUM_DLY; d++) begin : g_dly
    spi_limit_check #(.VAL_W(DLY_W), .ZERO_UNLIMITED(1'b0)) dly_i (
      .limit(cap_max_dly[d*DLY_W +: DLY_W]),
      .req  (req_dly[d*DLY_W +: DLY_W]),
      .ok   (dly_ok[d]));
  end

  assign all_ok = cs_ok & word_ok & toggle_ok & tx_ok & rx_ok & mode_ok
                & freq_ok & (&dly_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      code_q    <= RES_OK;
    end else begin
      res_valid <= req_valid;
      code_q    <= (req_valid && !all_ok) ? RES_PARAM_ERR : RES_OK;
    end
  end

  assign res_code = code_q;
endmodule

// File: rtl/spi_req_checker_sva.sv
module spi_req_checker_sva #(
  parameter int LANE_W  = 8,
  parameter int MODE_W  = 32,
  parameter int FREQ_W  = 32,
  parameter int DLY_W   = 32,
  parameter int NUM_DLY = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     req_valid,
  input logic [LANE_W-1:0]        req_tx_lanes,
  input logic [MODE_W-1:0]        req_mode,
  input logic [FREQ_W-1:0]        cap_max_freq,
  input logic [FREQ_W-1:0]        req_freq,
  input logic [NUM_DLY*DLY_W-1:0] cap_max_dly,
  input logic [NUM_DLY*DLY_W-1:0] req_dly,
  input logic                     res_valid,
  input logic [1:0]               res_code
);
  assert_strobe_latency_R1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (res_valid == $past(req_valid)));

  assert_code_range_R2: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_code <= 2'd1));

  assert_idle_code_R2: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (res_code == 2'd0));

  assert_bad_lane_R6: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid && !(req_tx_lanes inside {0, 1, 2, 4, 8}))
      |-> (res_valid && res_code == 2'd1));

  assert_reserved_mode_R10: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid && (req_mode[MODE_W-1:5] != '0))
      |-> (res_valid && res_code == 2'd1));

  assert_freq_over_R11: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid && cap_max_freq != '0 && req_freq > cap_max_freq)
      |-> (res_valid && res_code == 2'd1));

  for (genvar d = 0; d < NUM_DLY; d++) begin : g_dly
    assert_dly_unsup_R12: assert property (@(posedge clk) disable iff (rst)
      $past(!rst && req_valid && cap_max_dly[d*DLY_W +: DLY_W] == '0
            && req_dly[d*DLY_W +: DLY_W] != '0)
        |-> (res_valid && res_code == 2'd1));
  end

  assert_reset_clear_R13: assert property (@(posedge clk)
    $past(rst) |-> (!res_valid && res_code == 2'd0));
endmodule

bind spi_req_checker spi_req_checker_sva #(
  .LANE_W(LANE_W), .MODE_W(MODE_W), .FREQ_W(FREQ_W),
  .DLY_W(DLY_W), .NUM_DLY(NUM_DLY)
) sva_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_tx_lanes(req_tx_lanes),
  .req_mode(req_mode), .cap_max_freq(cap_max_freq), .req_freq(req_freq),
  .cap_max_dly(cap_max_dly), .req_dly(req_dly),
  .res_valid(res_valid), .res_code(res_code)
);

// File: tb/spi_req_checker_tb_top.sv
module spi_req_checker_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [7:0]   cap_cs_count;
  logic         cap_cs_toggle_unsup;
  logic [2:0]   cap_tx_lanes, cap_rx_lanes;
  logic [31:0]  cap_word_mask;
  logic [6:0]   cap_mode;
  logic [31:0]  cap_max_freq;
  logic [127:0] cap_max_dly;
  logic [7:0]   req_cs, req_word_bits;
  logic         req_cs_toggle;
  logic [7:0]   req_tx_lanes, req_rx_lanes;
  logic [31:0]  req_mode, req_freq;
  logic [127:0] req_dly;
  logic         res_valid;
  logic [1:0]   res_code;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  spi_req_checker dut_i (.*);

  // Behavioural reference: returns 1 when the request must be rejected
  function automatic int lane_bad(int v, int m);
    if (v == 0 || v == 1) return 0;
    if (v == 2) return (m & 1) ? 0 : 1;
    if (v == 4) return (m & 2) ? 0 : 1;
    if (v == 8) return (m & 4) ? 0 : 1;
    return 1;
  endfunction

  function automatic int sel_bad(int field, int want);
    if (field == 0) return 0;
    if (field == 1) return want;
    if (field == 2) return 1 - want;
    return 1;
  endfunction

  function automatic int ref_code();
    longint unsigned lim, rq;
    int bad = 0;
    if (req_cs >= cap_cs_count) bad = 1;
    if (cap_word_mask != 0) begin
      if (req_word_bits < 1 || req_word_bits > 32) bad = 1;
      else if (!cap_word_mask[req_word_bits-1]) bad = 1;
    end
    if (cap_cs_toggle_unsup && req_cs_toggle) bad = 1;
    if (lane_bad(req_tx_lanes, cap_tx_lanes) != 0) bad = 1;
    if (lane_bad(req_rx_lanes, cap_rx_lanes) != 0) bad = 1;
    if (sel_bad(cap_mode[1:0], req_mode[0]) != 0) bad = 1;
    if (sel_bad(cap_mode[3:2], req_mode[1]) != 0) bad = 1;
    if (req_mode[2] && !cap_mode[4]) bad = 1;
    if (req_mode[3] && !cap_mode[5]) bad = 1;
    if (req_mode[4] && !cap_mode[6]) bad = 1;
    if ((req_mode >> 5) != 0) bad = 1;
    if (cap_max_freq != 0 && req_freq > cap_max_freq) bad = 1;
    for (int k = 0; k < 4; k++) begin
      lim = cap_max_dly[k*32 +: 32];
      rq  = req_dly[k*32 +: 32];
      if (rq != 0 && (lim == 0 || rq > lim)) bad = 1;
    end
    return bad;
  endfunction

  task automatic check(input string tag, input logic ev, input int ec);
    n_vec++;
    if (res_valid !== ev || res_code !== 2'(ec)) begin
      n_bad++;
      $display("FAIL %s: valid=%0b code=%0d expected valid=%0b code=%0d",
               tag, res_valid, res_code, ev, ec);
    end
  endtask

  task automatic permissive();
    cap_cs_count = 8'd4; cap_cs_toggle_unsup = 1'b0;
    cap_tx_lanes = 3'b111; cap_rx_lanes = 3'b111;
    cap_word_mask = 32'h0; cap_mode = 7'b1110000;
    cap_max_freq = 32'd1000;
    cap_max_dly = {32'd50, 32'd40, 32'd30, 32'd20};
    req_cs = 8'd0; req_word_bits = 8'd8; req_cs_toggle = 1'b0;
    req_tx_lanes = 8'd1; req_rx_lanes = 8'd1; req_mode = 32'h0;
    req_freq = 32'd500; req_dly = '0;
  endtask

  // Drive at negedge, compare one clock later (R1)
  task automatic apply(input string tag, input int exp_code);
    int model;
    @(negedge clk);
    req_valid = 1'b1;
    model = ref_code();
    if (exp_code >= 0 && exp_code != model) begin
      n_bad++; n_vec++;
      $display("FAIL %s: model=%0d expected=%0d", tag, model, exp_code);
    end
    @(posedge clk); #2;
    check(tag, 1'b1, model);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #2;
    check("R1 idle/R2 zero code", 1'b0, 0);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    permissive();
    @(posedge clk); #2; check("R13 in reset", 1'b0, 0);
    @(negedge clk); req_valid = 1'b1;   // request during reset is dropped
    @(posedge clk); #2; check("R13 in reset", 1'b0, 0);
    @(negedge clk); rst = 1'b0; req_valid = 1'b0;
    @(posedge clk); #2; check("R13 after reset", 1'b0, 0);

    permissive(); apply("R2 benign pass", 0);
    permissive(); req_cs = 8'd3; apply("R3 cs=count-1", 0);
    permissive(); req_cs = 8'd4; apply("R3 cs=count", 1);
    permissive(); cap_word_mask = 32'h0000_0080; apply("R4 mask bit set", 0);
    permissive(); cap_word_mask = 32'h0000_0080; req_word_bits = 8'd9; apply("R4 mask bit clear", 1);
    permissive(); cap_word_mask = 32'h0000_0001; req_word_bits = 8'd0; apply("R4 zero word", 1);
    permissive(); cap_word_mask = 32'h8000_0000; req_word_bits = 8'd32; apply("R4 word 32", 0);
    permissive(); cap_word_mask = 32'hffff_ffff; req_word_bits = 8'd33; apply("R4 word 33", 1);
    permissive(); req_word_bits = 8'd200; apply("R4 zero mask any", 0);
    permissive(); req_cs_toggle = 1'b1; apply("R5 toggle supported", 0);
    permissive(); cap_cs_toggle_unsup = 1'b1; req_cs_toggle = 1'b1; apply("R5 toggle unsupported", 1);
    permissive(); cap_cs_toggle_unsup = 1'b1; apply("R5 no toggle", 0);
    permissive(); req_tx_lanes = 8'd3; apply("R6 tx lanes 3", 1);
    permissive(); req_rx_lanes = 8'd16; apply("R6 rx lanes 16", 1);
    permissive(); req_tx_lanes = 8'd0; req_rx_lanes = 8'd8; apply("R6 legal widths", 0);
    permissive(); cap_tx_lanes = 3'b101; req_tx_lanes = 8'd4; apply("R7 tx quad off", 1);
    permissive(); cap_rx_lanes = 3'b000; req_rx_lanes = 8'd1; apply("R7 single always", 0);
    permissive(); cap_rx_lanes = 3'b011; req_rx_lanes = 8'd8; apply("R7 rx octal off", 1);
    permissive(); cap_mode[1:0] = 2'b01; req_mode = 32'h1; apply("R8 phase only0", 1);
    permissive(); cap_mode[1:0] = 2'b10; req_mode = 32'h1; apply("R8 phase only1", 0);
    permissive(); cap_mode[3:2] = 2'b10; req_mode = 32'h0; apply("R8 pol only1", 1);
    permissive(); cap_mode[3:2] = 2'b11; apply("R8 invalid field", 1);
    permissive(); cap_mode = 7'b0000000; req_mode = 32'h4; apply("R9 select-high off", 1);
    permissive(); cap_mode = 7'b0100000; req_mode = 32'h8; apply("R9 lsb on", 0);
    permissive(); cap_mode = 7'b0010000; req_mode = 32'h10; apply("R9 loopback off", 1);
    permissive(); req_mode = 32'h20; apply("R10 bit5", 1);
    permissive(); req_mode = 32'h8000_0000; apply("R10 bit31", 1);
    permissive(); req_freq = 32'd1000; apply("R11 freq=max", 0);
    permissive(); req_freq = 32'd1001; apply("R11 freq>max", 1);
    permissive(); cap_max_freq = '0; req_freq = 32'hffff_ffff; apply("R11 unlimited", 0);
    permissive(); req_dly[31:0] = 32'd20; apply("R12 gap=max", 0);
    permissive(); req_dly[63:32] = 32'd31; apply("R12 setup>max", 1);
    permissive(); cap_max_dly[95:64] = '0; req_dly[95:64] = 32'd1; apply("R12 hold unsup", 1);
    permissive(); cap_max_dly = '0; apply("R12 zero req ok", 0);
    permissive(); cap_max_dly[127:96] = '0; req_dly[127:96] = 32'd5; apply("R12 inactive unsup", 1);

    for (int n = 0; n < 600; n++) begin
      cap_cs_count = 8'($urandom_range(0, 4));
      cap_cs_toggle_unsup = 1'($urandom);
      cap_tx_lanes = 3'($urandom); cap_rx_lanes = 3'($urandom);
      cap_word_mask = ($urandom_range(0, 1) == 0) ? 32'h0 : $urandom;
      cap_mode = 7'($urandom);
      cap_max_freq = ($urandom_range(0, 2) == 0) ? 32'h0 : 32'($urandom_range(1, 100));
      for (int k = 0; k < 4; k++)
        cap_max_dly[k*32 +: 32] = ($urandom_range(0, 2) == 0) ? 32'h0 : 32'($urandom_range(1, 9));
      req_cs = 8'($urandom_range(0, 4));
      req_word_bits = 8'($urandom_range(0, 34));
      req_cs_toggle = 1'($urandom);
      req_tx_lanes = 8'($urandom_range(0, 9));
      req_rx_lanes = 8'($urandom_range(0, 9));
      req_mode = ($urandom_range(0, 7) == 0) ? $urandom : 32'($urandom_range(0, 31));
      req_freq = 32'($urandom_range(0, 120));
      for (int k = 0; k < 4; k++)
        req_dly[k*32 +: 32] = ($urandom_range(0, 1) == 0) ? 32'h0 : 32'($urandom_range(1, 10));
      apply("R2-R12 random", -1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule